// File: doc/BRIEF.md
# Alarm Match and Interrupt Controller

This block sits beside a real-time clock's timekeeping logic and turns its events into one interrupt line. It watches three sources: the end of each time update, a periodic strobe from the divider chain, and an alarm. The alarm is found by comparing the current hours, minutes and seconds against three programmed alarm bytes. Any alarm byte can be set to "don't care", so the alarm can fire once a day, once an hour, once a minute or once a second.

Each source has a sticky flag. A flag is set whenever its event occurs, whether or not that source is enabled. A per-source enable mask decides which set flags drive the combined interrupt flag and the active-low request pin. A read strobe on the status register clears every flag at once. An event that lands in the same cycle as the read is kept. The update-ended flag marks the start of the window in which software can access the time registers without colliding with an update.

A two-state sequencer runs the alarm comparison. It sits in `CMP_IDLE` until the update strobe arrives (transition `START_EVAL`). It then spends one cycle in `CMP_EVAL`, where the freshly written time is compared with the alarm and the update and alarm events are raised. It then returns to `CMP_IDLE` (transition `EVAL_DONE`). If another update strobe arrives while in `CMP_EVAL`, it stays there for one more evaluation (transition `EVAL_AGAIN`).

Top module: `rtc_alarm_irq_ctrl`

## Requirements
- R1: After reset all flags are 0, `flags_o` is 4'b0000 and `irq_n` is 1.
- R2: A one-cycle `per_tick` sets the periodic flag `flags_o[2]` at the next clock edge, whatever the value of `en_per`.
- R3: A one-cycle `upd_done` at edge k sets the update-ended flag `flags_o[0]` at edge k+1, whatever the value of `en_upd`.
- R4: At edge k+1 after an `upd_done` at edge k, the alarm flag `flags_o[1]` is set when every alarm field equals its time field. For example, an alarm of 01:09:01 fires when the time is exactly 01:09:01.
- R5: An alarm field whose bits [7:6] are both 1 is don't-care and matches any time value in that field.
- R6: The alarm flag is not set when any field that is not don't-care differs from its time field. It is also not set without an update, even when the time and alarm match.
- R7: `flags_o[3]` is the OR over the sources of (flag AND enable), where bit 0 is update-ended with `en_upd`, bit 1 is alarm with `en_alm`, and bit 2 is periodic with `en_per`. `irq_n` is the inverse of `flags_o[3]`.
- R8: A set flag stays set until a status read.
- R9: `status_rd` high at an edge clears all flags at that edge, except a flag whose event occurs at the same edge, which stays set.
- R10: `status_valid` always reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_done | input | 1 | One-cycle strobe: time registers were just updated |
| per_tick | input | 1 | One-cycle periodic event strobe |
| cur_sec | input | 8 | Current seconds |
| cur_min | input | 8 | Current minutes |
| cur_hr | input | 8 | Current hours |
| alm_sec | input | 8 | Alarm seconds, 2'b11 in [7:6] = don't care |
| alm_min | input | 8 | Alarm minutes, 2'b11 in [7:6] = don't care |
| alm_hr | input | 8 | Alarm hours, 2'b11 in [7:6] = don't care |
| en_upd | input | 1 | Enable for the update-ended source |
| en_alm | input | 1 | Enable for the alarm source |
| en_per | input | 1 | Enable for the periodic source |
| status_rd | input | 1 | Status register read strobe, clears flags |
| flags_o | output | 4 | {irq flag, periodic, alarm, update-ended} |
| irq_n | output | 1 | Active-low interrupt request |
| status_valid | output | 1 | Validity bit, constant 1 |

## Verification
The checker watches on every cycle that the request pin mirrors the combined flag, and that a periodic or update strobe always leaves its flag set. It also checks that flags persist until a read, and that a read with no periodic event clears the periodic flag. Whether the alarm decision is right across combinations of don't-care fields and mismatched fields shows only in the bench's sweep, which works out the expected match from the field values. The same holds for the behaviour of every enable mask and for alarms that must stay silent without an update.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 3;
    localparam int NUM_SRC    = 3;
    localparam int SRC_UPD    = 0;
    localparam int SRC_ALM    = 1;
    localparam int SRC_PER    = 2;
    localparam int FLAG_W     = NUM_SRC + 1;

    typedef enum logic [0:0] {
        CMP_IDLE = 1'b0,
        CMP_EVAL = 1'b1
    } cmp_state_t;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
    parameter int W  = 8,
    parameter int NF = 3
) (
    input  logic [NF*W-1:0] cur_flat,
    input  logic [NF*W-1:0] alm_flat,
    output logic            all_hit
);
    logic [NF-1:0] field_hit;

    for (genvar f = 0; f < NF; f++) begin : g_field
        logic [W-1:0] cur_v;
        logic [W-1:0] alm_v;
        logic         wild;
        assign cur_v = cur_flat[f*W +: W];
        assign alm_v = alm_flat[f*W +: W];
        // top two bits both set marks the field as don't-care
        assign wild  = &alm_v[W-1:W-2];
        assign field_hit[f] = wild | (cur_v == alm_v);
    end

    assign all_hit = &field_hit;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr_all,
    input  logic [N-1:0] en,
    output logic [N-1:0] flag_q,
    output logic         irq_any
);
    for (genvar s = 0; s < N; s++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flag_q[s] <= 1'b0;
            else
                // a new event wins over a simultaneous read
                flag_q[s] <= evt[s] | (flag_q[s] & ~clr_all);
        end
    end

    assign irq_any = |(flag_q & en);
endmodule

// File: rtl/rtc_alarm_irq_ctrl.sv
module rtc_alarm_irq_ctrl
    import rtc_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd_done,
    input  logic       per_tick,
    input  logic [7:0] cur_sec,
    input  logic [7:0] cur_min,
    input  logic [7:0] cur_hr,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hr,
    input  logic       en_upd,
    input  logic       en_alm,
    input  logic       en_per,
    input  logic       status_rd,
    output logic [3:0] flags_o,
    output logic       irq_n,
    output logic       status_valid
);
    localparam int FLAT_W = NUM_FIELDS * FIELD_W;

    cmp_state_t           state_q, state_d;
    logic [FLAT_W-1:0]    cur_flat, alm_flat;
    logic                 alarm_hit;
    logic [NUM_SRC-1:0]   evt_vec, en_vec, flag_vec;
    logic                 irq_any;
    logic                 eval_now;

    assign cur_flat = {cur_hr, cur_min, cur_sec};
    assign alm_flat = {alm_hr, alm_min, alm_sec};

    alarm_field_cmp #(
        .W  (FIELD_W),
        .NF (NUM_FIELDS)
    ) u_cmp (
        .cur_flat (cur_flat),
        .alm_flat (alm_flat),
        .all_hit  (alarm_hit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= CMP_IDLE;
        else
            state_q <= state_d;
    end

    // next state: START_EVAL, EVAL_DONE, EVAL_AGAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMP_IDLE: if (upd_done) state_d = CMP_EVAL;
            CMP_EVAL: state_d = upd_done ? CMP_EVAL : CMP_IDLE;
            default:  state_d = CMP_IDLE;
        endcase
    end

    // outputs of the sequencer
    always_comb begin
        eval_now = 1'b0;
        unique case (state_q)
            CMP_IDLE: eval_now = 1'b0;
            CMP_EVAL: eval_now = 1'b1;
            default:  eval_now = 1'b0;
        endcase
    end

    always_comb begin
        evt_vec          = '0;
        evt_vec[SRC_UPD] = eval_now;
        evt_vec[SRC_ALM] = eval_now & alarm_hit;
        evt_vec[SRC_PER] = per_tick;
        en_vec           = '0;
        en_vec[SRC_UPD]  = en_upd;
        en_vec[SRC_ALM]  = en_alm;
        en_vec[SRC_PER]  = en_per;
    end

    irq_flag_bank #(
        .N (NUM_SRC)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt_vec),
        .clr_all (status_rd),
        .en      (en_vec),
        .flag_q  (flag_vec),
        .irq_any (irq_any)
    );

    assign flags_o      = {irq_any, flag_vec[SRC_PER], flag_vec[SRC_ALM], flag_vec[SRC_UPD]};
    assign irq_n        = ~irq_any;
    assign status_valid = 1'b1;
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       upd_done,
    input logic       per_tick,
    input logic       status_rd,
    input logic [3:0] flags_o,
    input logic       irq_n
);
    // R7: pin follows the combined flag
    a_r7_pin_matches_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == !flags_o[3]);

    // R2: periodic strobe always leaves its flag set
    a_r2_per_sets: assert property (@(posedge clk) disable iff (!rst_n)
        per_tick |=> flags_o[2]);

    // R3: update strobe sets the update-ended flag two edges on
    a_r3_upd_sets: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> ##2 flags_o[0]);

    // R8: flags persist without a read
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !status_rd |=> ((flags_o[2:0] & $past(flags_o[2:0])) == $past(flags_o[2:0])));

    // R9: a read without a periodic event clears the periodic flag
    a_r9_rd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !per_tick) |=> !flags_o[2]);
endmodule

bind rtc_alarm_irq_ctrl rtc_alarm_irq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_done  (upd_done),
    .per_tick  (per_tick),
    .status_rd (status_rd),
    .flags_o   (flags_o),
    .irq_n     (irq_n)
);

// File: tb/tb_rtc_alarm_irq_ctrl.sv
module tb_rtc_alarm_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd_done = 1'b0, per_tick = 1'b0, status_rd = 1'b0;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hr = '0;
    logic [7:0] alm_sec = '0, alm_min = '0, alm_hr = '0;
    logic       en_upd = 1'b0, en_alm = 1'b0, en_per = 1'b0;
    logic [3:0] flags_o;
    logic       irq_n, status_valid;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    rtc_alarm_irq_ctrl dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_update();
        @(negedge clk) upd_done = 1'b1;
        @(negedge clk) upd_done = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk) status_rd = 1'b1;
        @(negedge clk) status_rd = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 flags", flags_o, 4'b0000);
        chk("R1 irq_n", irq_n, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 valid", status_valid, 1'b1);

        // R2: periodic with enable off
        @(negedge clk) per_tick = 1'b1;
        @(negedge clk) per_tick = 1'b0;
        chk("R2 per flag", flags_o, 4'b0100);
        chk("R7 irq_n masked", irq_n, 1'b1);
        repeat (3) @(negedge clk);
        chk("R8 per sticky", flags_o, 4'b0100);
        do_read();
        chk("R9 cleared", flags_o, 4'b0000);

        // R4: exact 01:09:01, R3 update flag with enable off
        cur_hr = 8'h01; cur_min = 8'h09; cur_sec = 8'h01;
        alm_hr = 8'h01; alm_min = 8'h09; alm_sec = 8'h01;
        @(negedge clk);
        chk("R6 no alarm without update", flags_o, 4'b0000);
        en_alm = 1'b1;
        do_update();
        chk("R4 exact alarm R3 upd", flags_o, 4'b1011);
        chk("R7 irq_n low", irq_n, 1'b0);
        do_read();
        chk("R9 read releases irq", irq_n, 1'b1);

        // R5/R6 sweep: don't-care mask x mismatch field
        for (int m = 0; m < 8; m++) begin
            for (int x = 0; x < 4; x++) begin
                logic [7:0] base [3];
                logic       exp_hit;
                base[0] = 8'd30; base[1] = 8'd45; base[2] = 8'd17;
                cur_sec = base[0]; cur_min = base[1]; cur_hr = base[2];
                alm_sec = m[0] ? 8'hC0 | 8'(m) : base[0];
                alm_min = m[1] ? 8'hC5 : base[1];
                alm_hr  = m[2] ? 8'hFF : base[2];
                if (x == 1) cur_sec = base[0] + 8'd1;
                if (x == 2) cur_min = base[1] + 8'd1;
                if (x == 3) cur_hr  = base[2] + 8'd1;
                exp_hit = (x == 0) || m[x-1];
                do_update();
                chk(exp_hit ? "R5 dont-care hit" : "R6 mismatch no hit",
                    flags_o[1], exp_hit);
                chk("R3 upd each time", flags_o[0], 1'b1);
                do_read();
            end
        end

        // R7 enable sweep with all three flags set
        cur_sec = 8'd5; alm_sec = 8'd5; alm_min = 8'hC0; alm_hr = 8'hC0;
        for (int e = 0; e < 8; e++) begin
            en_upd = e[0]; en_alm = e[1]; en_per = e[2];
            @(negedge clk) per_tick = 1'b1;
            @(negedge clk) per_tick = 1'b0;
            do_update();
            chk("R7 irq flag", flags_o[3], e != 0);
            chk("R7 irq pin", irq_n, e == 0);
            do_read();
        end

        // R9: event in the same cycle as the read survives
        en_upd = 1'b0; en_alm = 1'b0; en_per = 1'b1;
        @(negedge clk) begin status_rd = 1'b1; per_tick = 1'b1; end
        @(negedge clk) begin status_rd = 1'b0; per_tick = 1'b0; end
        chk("R9 same-cycle event kept", flags_o, 4'b1100);
        // update already set, read at the eval edge: update flag kept
        do_read();
        @(negedge clk) upd_done = 1'b1;
        @(negedge clk) begin upd_done = 1'b0; status_rd = 1'b1; end
        @(negedge clk) status_rd = 1'b0;
        chk("R9 update kept on read", flags_o[2:0], 3'b011);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule